// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block performs the stack and vector-table work that a 16-bit segmented processor needs to enter and leave interrupt service routines. It holds the architectural flags, code segment (CS), instruction pointer (IP) and stack pointer (SP). It also serves four kinds of request: a software interrupt with an 8-bit type, a breakpoint, an overflow trap, and a level-sensitive maskable external request. An interrupt-return command unwinds an entry. Further commands set or clear the interrupt-enable flag, load the flags word and halt the processor.

The execution unit hands over one command at a time. Each command carries the IP of the next instruction, which becomes the current IP when the command is accepted. The sequencer then drives a word-wide memory port. It pushes to the stack at `stack_seg`×16 + offset and reads the two vector words from the table at the bottom of memory. Every access waits for `mem_ready`.

The state machine has these states:
- `ST_IDLE`: between instructions.
- `ST_HALT`: halted.
- `ST_PSH_FL`, `ST_PSH_CS`, `ST_PSH_IP`: the three entry pushes.
- `ST_VEC_IP`, `ST_VEC_CS`: the two vector reads.
- `ST_POP_IP`, `ST_POP_CS`, `ST_POP_FL`: the three return pops.

The transitions are:
- IDLE goes to PSH_FL on a software interrupt, a breakpoint, a taken overflow trap or an accepted external request.
- IDLE goes to POP_IP on a return.
- IDLE goes to HALT on halt.
- HALT goes to PSH_FL on an accepted external request.
- Each memory state advances to the next one in the chain when `mem_ready` is high.
- VEC_CS and POP_FL return to IDLE.

Top module: `intr_seq`

## Requirements
- R1: After reset the block is in IDLE with `cmd_ready`=1 and `mem_req`=0. The outputs reset to flags 16'h0002, CS 16'hF000, IP 16'hFFF0 and SP 16'h0100.
- R2: An entry makes three writes in this order: flags at SP-2, CS at SP-4, and the return IP at SP-6. All three offsets are relative to the SP at entry and lie in `stack_seg`. SP ends 6 lower. For a command, the return IP is `cmd_ip`.
- R3: The flags word pushed is the value before entry. Once the flags push completes, trap (bit 8) and interrupt-enable (bit 9) are cleared, and the other bits are kept.
- R4: After the pushes, the block reads the word at type×4 into IP and then the word at type×4+2 into CS, then returns to IDLE.
- R5: Operation codes on `cmd_op` are: 0 software interrupt (type from `cmd_type`), 1 breakpoint (type 3), 2 overflow trap (type 4), 3 return, 4 set enable, 5 clear enable, 6 halt, 7 load flags.
- R6: An overflow trap with overflow (bit 11) clear makes no memory access. It only sets IP to `cmd_ip`, and `cmd_ready` is high again the next cycle.
- R7: A return reads IP from SP, CS from SP+2 and flags from SP+4, and leaves SP 6 higher.
- R8: Set-enable sets flags bit 9 and clear-enable clears it, with no memory access.
- R9: `intr_req` is accepted only when bit 9 is 1 and the block is either halted or idle with no command offered. Acceptance is flagged by a one-cycle `intr_ack`, and the vector type comes from `intr_type`.
- R10: When a command is offered in the same cycle as an acceptable `intr_req`, the command is taken first and `intr_ack` stays low.
- R11: After halt, `cmd_ready` stays low until an external request is accepted or reset is asserted. The IP pushed is the `cmd_ip` given with the halt.
- R12: During a memory access, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` is sampled high.
- R13: Load-flags replaces the whole flags word with `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Operation code (R5) |
| cmd_type | input | 8 | Software interrupt type |
| cmd_ip | input | 16 | IP of the next instruction |
| cmd_data | input | 16 | Flags word for load-flags |
| cmd_ready | output | 1 | Block is between instructions |
| intr_req | input | 1 | External maskable request, level |
| intr_type | input | 8 | Vector type of external request |
| intr_ack | output | 1 | External request accepted |
| stack_seg | input | 16 | Stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word |
| mem_ready | input | 1 | Access completes this cycle |
| flags_o | output | 16 | Flags |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |

## Verification
A wrong state register shows up at the memory port at the very next access. A skipped or repeated push puts the wrong word or offset on the bus, and it appears a cycle after the state would have advanced. A wrong vector type or a corrupted SP puts a bad address on the first read or push that uses it. Errors in the enable flag show at `intr_ack` in the same cycle as the request: a request acknowledged while masked, or one left pending while enabled. A return that unwinds in the wrong order shows as swapped IP, CS or flags as soon as `cmd_ready` rises again.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HALT,
        ST_PSH_FL,
        ST_PSH_CS,
        ST_PSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_SWI  = 3'd0,
        OP_BRK  = 3'd1,
        OP_OVT  = 3'd2,
        OP_IRET = 3'd3,
        OP_SETI = 3'd4,
        OP_CLRI = 3'd5,
        OP_HALT = 3'd6,
        OP_WRFL = 3'd7
    } seq_op_e;

    localparam int FL_TRAP  = 8;
    localparam int FL_IEN   = 9;
    localparam int FL_OVF   = 11;
    localparam int BRK_TYPE = 3;
    localparam int OVT_TYPE = 4;

    function automatic logic is_push(seq_state_e s);
        return (s == ST_PSH_FL) || (s == ST_PSH_CS) || (s == ST_PSH_IP);
    endfunction

    function automatic logic is_pop(seq_state_e s);
        return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_FL);
    endfunction

    function automatic logic is_mem(seq_state_e s);
        return is_push(s) || is_pop(s) || (s == ST_VEC_IP) || (s == ST_VEC_CS);
    endfunction

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
    import intr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  seq_op_e    cmd_op,
    input  logic       ovf_flag,
    input  logic       ien_flag,
    input  logic       intr_req,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       cmd_ready,
    output logic       cmd_fire,
    output logic       intr_take,
    output logic       mem_req,
    output logic       mem_we,
    output logic       xfer_done
);

    seq_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_fire) begin
                    unique case (cmd_op)
                        OP_SWI, OP_BRK: state_nx = ST_PSH_FL;
                        OP_OVT:         state_nx = ovf_flag ? ST_PSH_FL : ST_IDLE;
                        OP_IRET:        state_nx = ST_POP_IP;
                        OP_HALT:        state_nx = ST_HALT;
                        default:        state_nx = ST_IDLE;
                    endcase
                end else if (intr_take) begin
                    state_nx = ST_PSH_FL;
                end
            end
            ST_HALT:   if (intr_take) state_nx = ST_PSH_FL;
            ST_PSH_FL: if (mem_ready) state_nx = ST_PSH_CS;
            ST_PSH_CS: if (mem_ready) state_nx = ST_PSH_IP;
            ST_PSH_IP: if (mem_ready) state_nx = ST_VEC_IP;
            ST_VEC_IP: if (mem_ready) state_nx = ST_VEC_CS;
            ST_VEC_CS: if (mem_ready) state_nx = ST_IDLE;
            ST_POP_IP: if (mem_ready) state_nx = ST_POP_CS;
            ST_POP_CS: if (mem_ready) state_nx = ST_POP_FL;
            ST_POP_FL: if (mem_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        cmd_fire  = cmd_valid && cmd_ready;
        mem_req   = is_mem(state);
        mem_we    = is_push(state);
        xfer_done = mem_req && mem_ready;
        unique case (state)
            ST_IDLE: intr_take = intr_req && ien_flag && !cmd_valid;
            ST_HALT: intr_take = intr_req && ien_flag;
            default: intr_take = 1'b0;
        endcase
    end

endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
    import intr_seq_pkg::*;
#(
    parameter int              WORD_W      = 16,
    parameter int              TYPE_W      = 8,
    parameter logic [WORD_W-1:0] RESET_FLAGS = 16'h0002,
    parameter logic [WORD_W-1:0] RESET_CS    = 16'hF000,
    parameter logic [WORD_W-1:0] RESET_IP    = 16'hFFF0,
    parameter logic [WORD_W-1:0] RESET_SP    = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              cmd_fire,
    input  seq_op_e           cmd_op,
    input  logic [TYPE_W-1:0] cmd_type,
    input  logic [WORD_W-1:0] cmd_ip,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              intr_take,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] flags,
    output logic [WORD_W-1:0] cs,
    output logic [WORD_W-1:0] ip,
    output logic [WORD_W-1:0] sp,
    output logic [TYPE_W-1:0] vtype
);

    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= RESET_FLAGS;
            cs    <= RESET_CS;
            ip    <= RESET_IP;
            sp    <= RESET_SP;
            vtype <= '0;
        end else begin
            if (cmd_fire) begin
                ip <= cmd_ip;
                unique case (cmd_op)
                    OP_SWI:  vtype <= cmd_type;
                    OP_BRK:  vtype <= TYPE_W'(BRK_TYPE);
                    OP_OVT:  vtype <= TYPE_W'(OVT_TYPE);
                    OP_SETI: flags[FL_IEN] <= 1'b1;
                    OP_CLRI: flags[FL_IEN] <= 1'b0;
                    OP_WRFL: flags <= cmd_data;
                    default: ;
                endcase
            end else if (intr_take) begin
                vtype <= intr_type;
            end
            if (xfer_done) begin
                unique case (state)
                    ST_PSH_FL: begin
                        sp             <= sp - STEP;
                        flags[FL_TRAP] <= 1'b0;
                        flags[FL_IEN]  <= 1'b0;
                    end
                    ST_PSH_CS, ST_PSH_IP: sp <= sp - STEP;
                    ST_VEC_IP: ip <= mem_rdata;
                    ST_VEC_CS: cs <= mem_rdata;
                    ST_POP_IP: begin ip    <= mem_rdata; sp <= sp + STEP; end
                    ST_POP_CS: begin cs    <= mem_rdata; sp <= sp + STEP; end
                    ST_POP_FL: begin flags <= mem_rdata; sp <= sp + STEP; end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/intr_seq_agu.sv
module intr_seq_agu
    import intr_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16,
    parameter int TYPE_W = 8
) (
    input  seq_state_e        state,
    input  logic [WORD_W-1:0] seg,
    input  logic [WORD_W-1:0] sp,
    input  logic [WORD_W-1:0] flags,
    input  logic [WORD_W-1:0] cs,
    input  logic [WORD_W-1:0] ip,
    input  logic [TYPE_W-1:0] vtype,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);

    localparam int SEG_SHIFT = ADDR_W - WORD_W;
    localparam int VEC_PAD   = ADDR_W - TYPE_W - 2;

    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] pop_addr;
    logic [ADDR_W-1:0] vec_base;
    logic [WORD_W-1:0] sp_dn;

    always_comb begin
        sp_dn     = sp - WORD_W'(2);
        seg_base  = ADDR_W'(seg) << SEG_SHIFT;
        push_addr = seg_base + ADDR_W'(sp_dn);
        pop_addr  = seg_base + ADDR_W'(sp);
        vec_base  = {{VEC_PAD{1'b0}}, vtype, 2'b00};
    end

    always_comb begin
        addr  = '0;
        wdata = '0;
        unique case (state)
            ST_PSH_FL: begin addr = push_addr; wdata = flags; end
            ST_PSH_CS: begin addr = push_addr; wdata = cs;    end
            ST_PSH_IP: begin addr = push_addr; wdata = ip;    end
            ST_VEC_IP: addr = vec_base;
            ST_VEC_CS: addr = vec_base + ADDR_W'(2);
            ST_POP_IP, ST_POP_CS, ST_POP_FL: addr = pop_addr;
            default: ;
        endcase
    end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_seq_pkg::*;
#(
    parameter int                ADDR_W      = 20,
    parameter int                WORD_W      = 16,
    parameter int                TYPE_W      = 8,
    parameter logic [WORD_W-1:0] RESET_FLAGS = 16'h0002,
    parameter logic [WORD_W-1:0] RESET_CS    = 16'hF000,
    parameter logic [WORD_W-1:0] RESET_IP    = 16'hFFF0,
    parameter logic [WORD_W-1:0] RESET_SP    = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [TYPE_W-1:0] cmd_type,
    input  logic [WORD_W-1:0] cmd_ip,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              cmd_ready,
    input  logic              intr_req,
    input  logic [TYPE_W-1:0] intr_type,
    output logic              intr_ack,
    input  logic [WORD_W-1:0] stack_seg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [WORD_W-1:0] flags_o,
    output logic [WORD_W-1:0] cs_o,
    output logic [WORD_W-1:0] ip_o,
    output logic [WORD_W-1:0] sp_o
);

    seq_op_e           op;
    seq_state_e        state;
    logic              cmd_fire;
    logic              xfer_done;
    logic [TYPE_W-1:0] vtype;

    assign op = seq_op_e'(cmd_op);

    intr_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .ovf_flag  (flags_o[FL_OVF]),
        .ien_flag  (flags_o[FL_IEN]),
        .intr_req  (intr_req),
        .mem_ready (mem_ready),
        .state     (state),
        .cmd_ready (cmd_ready),
        .cmd_fire  (cmd_fire),
        .intr_take (intr_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .xfer_done (xfer_done)
    );

    intr_seq_regs #(
        .WORD_W      (WORD_W),
        .TYPE_W      (TYPE_W),
        .RESET_FLAGS (RESET_FLAGS),
        .RESET_CS    (RESET_CS),
        .RESET_IP    (RESET_IP),
        .RESET_SP    (RESET_SP)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .cmd_fire  (cmd_fire),
        .cmd_op    (op),
        .cmd_type  (cmd_type),
        .cmd_ip    (cmd_ip),
        .cmd_data  (cmd_data),
        .intr_take (intr_ack),
        .intr_type (intr_type),
        .xfer_done (xfer_done),
        .mem_rdata (mem_rdata),
        .flags     (flags_o),
        .cs        (cs_o),
        .ip        (ip_o),
        .sp        (sp_o),
        .vtype     (vtype)
    );

    intr_seq_agu #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .TYPE_W (TYPE_W)
    ) u_agu (
        .state (state),
        .seg   (stack_seg),
        .sp    (sp_o),
        .flags (flags_o),
        .cs    (cs_o),
        .ip    (ip_o),
        .vtype (vtype),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
    import intr_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        state,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input seq_op_e           cmd_op,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] flags_o,
    input logic [WORD_W-1:0] sp_o,
    input logic              intr_ack
);

    assert_push_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (sp_o == $past(sp_o) - WORD_W'(2)));

    assert_clear_ti_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PSH_FL && mem_ready) |=> (!flags_o[FL_TRAP] && !flags_o[FL_IEN]));

    assert_ovt_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_OVT && !flags_o[FL_OVF])
        |=> (cmd_ready && !mem_req));

    assert_pop_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && is_pop(state))
        |=> (sp_o == $past(sp_o) + WORD_W'(2)));

    assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_o[FL_IEN] |-> !intr_ack);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |=> !intr_ack);

    assert_cmd_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |-> !intr_ack);

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !cmd_ready);

    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind intr_seq intr_seq_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (op),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .flags_o   (flags_o),
    .sp_o      (sp_o),
    .intr_ack  (intr_ack)
);

// File: tb/intr_seq_bench.sv
`timescale 1ns/1ps
module intr_seq_bench;
    import intr_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_type = '0;
    logic [15:0] cmd_ip = '0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic        intr_req = 1'b0;
    logic [7:0]  intr_type = '0;
    logic        intr_ack;
    logic [15:0] stack_seg = 16'h2000;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [15:0] flags_o, cs_o, ip_o, sp_o;

    always #2 clk = ~clk;

    intr_seq u_intr_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_type(cmd_type), .cmd_ip(cmd_ip), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .intr_req(intr_req), .intr_type(intr_type),
        .intr_ack(intr_ack), .stack_seg(stack_seg), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .flags_o(flags_o),
        .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o)
    );

    typedef struct {
        logic        we;
        logic [19:0] addr;
        logic [15:0] data;
    } xfer_t;

    xfer_t       exp_q[$];
    logic [15:0] mem[int];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [15:0] m_flags, m_cs, m_ip, m_sp;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(logic [15:0] off);
        return {stack_seg, 4'h0} + {4'h0, off};
    endfunction

    function automatic logic [15:0] rdmem(logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // memory responder and scoreboard monitor
    int          xfer_no = 0;
    int          wait_cnt = 0;
    logic        busy = 1'b0;
    logic [19:0] hold_addr;
    always @(negedge clk) begin
        if (mem_req && !busy) begin
            busy = 1'b1;
            wait_cnt = xfer_no % 3;
            hold_addr = mem_addr;
        end
        if (busy) begin
            if (mem_addr !== hold_addr) chk("R12 address held", 32'(mem_addr), 32'(hold_addr));
            if (wait_cnt == 0) begin
                if (exp_q.size() == 0) begin
                    chk("R2/R4/R7 unexpected transfer", 32'(mem_addr), 32'hFFFFFFFF);
                end else begin
                    xfer_t e;
                    e = exp_q.pop_front();
                    chk("R2/R4/R7 transfer direction", 32'(mem_we), 32'(e.we));
                    chk("R2/R4/R7 transfer address", 32'(mem_addr), 32'(e.addr));
                    if (e.we) chk("R2/R3 pushed word", 32'(mem_wdata), 32'(e.data));
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                else        mem_rdata = rdmem(mem_addr);
                mem_ready = 1'b1;
                busy = 1'b0;
                xfer_no++;
            end else begin
                wait_cnt--;
                mem_ready = 1'b0;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    // driver side: expected transfers
    task automatic model_entry(logic [7:0] t, logic [15:0] ret_ip);
        logic [19:0] v;
        v = {10'h0, t, 2'b00};
        exp_q.push_back('{1'b1, phys(m_sp - 16'd2), m_flags});
        exp_q.push_back('{1'b1, phys(m_sp - 16'd4), m_cs});
        exp_q.push_back('{1'b1, phys(m_sp - 16'd6), ret_ip});
        exp_q.push_back('{1'b0, v, 16'h0});
        exp_q.push_back('{1'b0, v + 20'd2, 16'h0});
        m_flags = m_flags & ~16'h0300;
        m_sp    = m_sp - 16'd6;
        m_ip    = rdmem(v);
        m_cs    = rdmem(v + 20'd2);
    endtask

    task automatic model_return();
        exp_q.push_back('{1'b0, phys(m_sp), 16'h0});
        exp_q.push_back('{1'b0, phys(m_sp + 16'd2), 16'h0});
        exp_q.push_back('{1'b0, phys(m_sp + 16'd4), 16'h0});
        m_ip    = rdmem(phys(m_sp));
        m_cs    = rdmem(phys(m_sp + 16'd2));
        m_flags = rdmem(phys(m_sp + 16'd4));
        m_sp    = m_sp + 16'd6;
    endtask

    task automatic issue(seq_op_e op, logic [7:0] t, logic [15:0] ip, logic [15:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        unique case (op)
            OP_SWI:  model_entry(t, ip);
            OP_BRK:  model_entry(8'd3, ip);
            OP_OVT:  if (m_flags[11]) model_entry(8'd4, ip);
            OP_IRET: model_return();
            OP_SETI: m_flags[9] = 1'b1;
            OP_CLRI: m_flags[9] = 1'b0;
            OP_WRFL: m_flags = d;
            default: ;
        endcase
        if (!(op inside {OP_SWI, OP_BRK, OP_OVT, OP_IRET})) m_ip = ip;
        else if (op == OP_OVT && !m_flags[11]) m_ip = ip;
        cmd_valid = 1'b1; cmd_op = op; cmd_type = t; cmd_ip = ip; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cmd_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    task automatic check_state(string tag);
        chk({tag, " flags"}, 32'(flags_o), 32'(m_flags));
        chk({tag, " CS"},    32'(cs_o),    32'(m_cs));
        chk({tag, " IP"},    32'(ip_o),    32'(m_ip));
        chk({tag, " SP"},    32'(sp_o),    32'(m_sp));
    endtask

    task automatic raise_intr(logic [7:0] t, string tag);
        model_entry(t, m_ip);
        intr_type = t;
        intr_req = 1'b1;
        #1;
        chk(tag, 32'(intr_ack), 32'd1);
        @(negedge clk);
        intr_req = 1'b0;
        chk("R9 ack is one cycle", 32'(intr_ack), 32'd0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_flags = 16'h0002; m_cs = 16'hF000; m_ip = 16'hFFF0; m_sp = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        check_state("R1 reset");

        // R13: load flags with T, I, O set
        issue(OP_WRFL, 8'h00, 16'h0010, 16'h0B00);
        wait_idle(); check_state("R13 load flags");

        // R2 R3 R4: software interrupt
        issue(OP_SWI, 8'h21, 16'h0012, 16'h0);
        wait_idle(); check_state("R2/R3/R4 software entry");
        chk("R3 T and I clear", 32'(flags_o & 16'h0300), 32'd0);

        // R7: return
        issue(OP_IRET, 8'h00, 16'h0, 16'h0);
        wait_idle(); check_state("R7 return");
        chk("R7 IP restored", 32'(ip_o), 32'h0012);

        // R5: breakpoint type 3
        issue(OP_BRK, 8'h77, 16'h0020, 16'h0);
        wait_idle(); check_state("R5 breakpoint");
        issue(OP_IRET, 8'h00, 16'h0, 16'h0);
        wait_idle(); check_state("R7 return from breakpoint");

        // R6: overflow trap with O clear
        issue(OP_WRFL, 8'h00, 16'h0022, 16'h0200);
        issue(OP_OVT, 8'h00, 16'h0030, 16'h0);
        chk("R6 ready next cycle", 32'(cmd_ready), 32'd1);
        chk("R6 no access", 32'(mem_req), 32'd0);
        wait_idle(); check_state("R6 trap skipped");

        // R5: overflow trap with O set, type 4
        issue(OP_WRFL, 8'h00, 16'h0032, 16'h0A00);
        issue(OP_OVT, 8'h00, 16'h0040, 16'h0);
        wait_idle(); check_state("R5 overflow trap taken");
        issue(OP_IRET, 8'h00, 16'h0, 16'h0);
        wait_idle(); check_state("R7 return from trap");

        // R8
        issue(OP_CLRI, 8'h00, 16'h0042, 16'h0);
        wait_idle(); chk("R8 clear enable", 32'(flags_o[9]), 32'd0);
        issue(OP_SETI, 8'h00, 16'h0044, 16'h0);
        wait_idle(); chk("R8 set enable", 32'(flags_o[9]), 32'd1);
        check_state("R8 enable state");

        // R9: accepted external request
        @(negedge clk);
        raise_intr(8'h08, "R9 ack when enabled");
        wait_idle(); check_state("R9 external entry");
        issue(OP_IRET, 8'h00, 16'h0, 16'h0);
        wait_idle(); check_state("R7 return from external");

        // R9: masked request
        issue(OP_CLRI, 8'h00, 16'h0046, 16'h0);
        wait_idle();
        intr_type = 8'h09; intr_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            #1; chk("R9 masked no ack", 32'(intr_ack), 32'd0);
            @(negedge clk);
        end
        intr_req = 1'b0;
        check_state("R9 masked no entry");

        // R10: command wins over same-cycle request
        issue(OP_SETI, 8'h00, 16'h0048, 16'h0);
        wait_idle();
        m_flags[9] = 1'b0; m_ip = 16'h004A;
        intr_req = 1'b1;
        cmd_valid = 1'b1; cmd_op = OP_CLRI; cmd_ip = 16'h004A;
        #1; chk("R10 command first", 32'(intr_ack), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1; chk("R10 request then masked", 32'(intr_ack), 32'd0);
            @(negedge clk);
        end
        intr_req = 1'b0;
        check_state("R10 after command");

        // R11: halt until external request
        issue(OP_SETI, 8'h00, 16'h004C, 16'h0);
        issue(OP_HALT, 8'h00, 16'h0050, 16'h0);
        for (int i = 0; i < 6; i++) begin
            chk("R11 halted not ready", 32'(cmd_ready), 32'd0);
            @(negedge clk);
        end
        chk("R11 halt IP", 32'(ip_o), 32'h0050);
        raise_intr(8'h0A, "R11 wake on request");
        wait_idle(); check_state("R11 entry from halt");
        issue(OP_IRET, 8'h00, 16'h0, 16'h0);
        wait_idle(); check_state("R11 resume after halt");
        chk("R12 queue drained", 32'(exp_q.size()), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule